// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block gathers up to 32 interrupt request lines and reduces them to two active-low processor lines: a fast-interrupt line and a normal-interrupt line. Each source has its own priority level from 0 (most urgent) to 7 (least urgent), an enable bit and a sensitivity mode: high level, low level, falling edge or rising edge. Software reaches all of these through a 32-bit APB slave.

Arbitration works in two tiers. The lowest-numbered enabled, pending source at level 0 drives the fast line. Sources at levels 1 to 7 compete for the normal line. The lower level number wins, and on a tie the lower channel wins. Software reads a vector register to acknowledge a request. The read returns the winning channel, records that channel's level on an in-service stack and clears the edge flag of that channel. While a level is in service, only sources at strictly more urgent levels can raise the normal line again. A write to the end-of-command register pops the stack, and later arbitration resumes from the level below.

The APB side is a plain register port. Every access completes in its access phase, so `pready` is held high and the block never applies back-pressure. All other pins are plain level signals.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every source reads back level 7 in high-level mode (control value 0x07), all enables read 0, pending reads 0, both `nirq_o` and `nfiq_o` are high, and the in-service stack is empty.
- R2: The control register of source i is at byte offset 4*i. Bits [2:0] hold the level and bits [4:3] hold the mode: 0 = high level, 1 = low level, 2 = falling edge, 3 = rising edge. The register reads back what was written.
- R3: Writing 1s to offset 0x080 sets enable bits, and reading 0x080 returns the enable mask. Writing 1s to offset 0x084 clears enable bits. A disabled source never pulls either output low.
- R4: Offset 0x08C reads the pending vector, which ignores the enables. For a level-mode source, bit i is the synchronized input, inverted in low-level mode. Offset 0x088 reads the synchronized raw inputs.
- R5: In an edge mode, the selected transition sets the source's pending flag. The flag stays set after the input returns, until the source is acknowledged or its mode is changed to a level mode.
- R6: Among eligible sources, the lower level number wins, and on equal levels the lower channel wins. Reading offset 0x090 returns bit 31 = 1 with the winning channel in bits [7:0], or 0 when no normal-line winner exists.
- R7: An enabled, pending level-0 source pulls `nfiq_o` low even while a normal interrupt is in service. Reading offset 0x094 returns the fast winner in the same format. Levels 1 to 7 only ever drive `nirq_o`.
- R8: A vector read that returns a winner acknowledges it. The read pushes the winner's level (0 for the fast vector) and clears that source's edge flag. A vector read with no winner returns 0 and pushes nothing.
- R9: While level L is on top of the in-service stack, `nirq_o` is driven low only by sources whose level is above 0 and below L.
- R10: Any write to offset 0x098 pops one entry from the in-service stack. A write when the stack is empty changes nothing.
- R11: While level 0 is on top of the in-service stack, `nfiq_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | Always high: no wait states |
| src_i | input | NSRC | Raw interrupt request lines |
| nirq_o | output | 1 | Normal interrupt request, active low, registered |
| nfiq_o | output | 1 | Fast interrupt request, active low, registered |

## Verification
An input change reaches the pending register after two clock edges in a level mode and after three in an edge mode. It reaches `nirq_o`/`nfiq_o` one edge after that. A vector read or end-of-command write takes effect at the edge that ends its access phase, and the output lines follow one edge later. The bench therefore waits six cycles after each input change and three cycles after each register access before it samples. It samples at a point away from the rising edge and compares against a bench-side model of the pins, flags, enables and stack.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = 1 << LVL_W;

  typedef enum logic [1:0] {
    SENSE_HIGH = 2'd0,
    SENSE_LOW  = 2'd1,
    SENSE_FALL = 2'd2,
    SENSE_RISE = 2'd3
  } sense_mode_e;

  localparam logic [11:0] OFS_EN_SET  = 12'h080;
  localparam logic [11:0] OFS_EN_CLR  = 12'h084;
  localparam logic [11:0] OFS_RAW     = 12'h088;
  localparam logic [11:0] OFS_PEND    = 12'h08C;
  localparam logic [11:0] OFS_IRQ_VEC = 12'h090;
  localparam logic [11:0] OFS_FIQ_VEC = 12'h094;
  localparam logic [11:0] OFS_EOC     = 12'h098;
endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond
  import prio_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pin,
  input  sense_mode_e mode,
  input  logic        ack_clr,
  output logic        raw,
  output logic        req
);
  logic s1_q, s2_q, s3_q, flag_q;
  logic edge_hit, is_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_comb begin
    is_edge = mode[1];
    unique case (mode)
      SENSE_RISE: edge_hit = s2_q & ~s3_q;
      SENSE_FALL: edge_hit = ~s2_q & s3_q;
      default:    edge_hit = 1'b0;
    endcase
  end

  // a new edge wins over an acknowledge in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= is_edge & ((flag_q & ~ack_clr) | edge_hit);
  end

  assign raw = s2_q;
  assign req = is_edge ? flag_q : (s2_q ^ (mode == SENSE_LOW));

  assert_flag_cleared_on_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr && !edge_hit) |=> !flag_q);
  assert_flag_only_in_edge_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !is_edge |=> !flag_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int CH_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]            req,
  input  logic [NSRC-1:0][LVL_W-1:0] lvl,
  input  logic [LVL_W:0]             thr,
  output logic                       irq_valid,
  output logic [CH_W-1:0]            irq_ch,
  output logic [LVL_W-1:0]           irq_lvl,
  output logic                       fiq_valid,
  output logic [CH_W-1:0]            fiq_ch
);
  localparam logic [LVL_W:0] NONE = (LVL_W+1)'(NUM_LVL);
  logic [LVL_W:0] best;

  // scan from the top channel down so equal levels resolve to the lower channel
  always_comb begin
    irq_valid = 1'b0;
    irq_ch    = '0;
    irq_lvl   = '0;
    fiq_valid = 1'b0;
    fiq_ch    = '0;
    best      = NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i] && lvl[i] != '0 && {1'b0, lvl[i]} < thr && {1'b0, lvl[i]} <= best) begin
        irq_valid = 1'b1;
        irq_ch    = CH_W'(i);
        irq_lvl   = lvl[i];
        best      = {1'b0, lvl[i]};
      end
      if (req[i] && lvl[i] == '0 && thr != '0) begin
        fiq_valid = 1'b1;
        fiq_ch    = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/isr_stack.sv
module isr_stack
  import prio_irq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic           pop,
  output logic [LVL_W:0] thr
);
  localparam int DEPTH = NUM_LVL;
  localparam int CNT_W = LVL_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [LVL_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [LVL_W-1:0] top_idx;

  assign top_idx = LVL_W'(cnt_q - 1'b1);
  assign thr     = (cnt_q == '0) ? CNT_W'(NUM_LVL) : {1'b0, mem_q[top_idx]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push && cnt_q != FULL) begin
      mem_q[cnt_q[LVL_W-1:0]] <= push_lvl;
      cnt_q <= cnt_q + 1'b1;
    end else if (pop && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_no_push_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt_q != FULL);
  assert_push_strictly_above_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && cnt_q != '0) |-> push_lvl < mem_q[top_idx]);
  assert_empty_pop_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            pclk,
  input  logic            presetn,
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [11:0]     paddr,
  input  logic [31:0]     pwdata,
  output logic [31:0]     prdata,
  output logic            pready,
  input  logic [NSRC-1:0] src_i,
  output logic            nirq_o,
  output logic            nfiq_o
);
  localparam int CH_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0][LVL_W-1:0] lvl_q;
  logic [NSRC-1:0][1:0]       mode_q;
  logic [NSRC-1:0]            en_q, raw_v, req_v, ack_v;
  logic [9:0]                 word_idx;
  logic                       wr, rd, ctrl_hit, ack_irq, ack_fiq, pop;
  logic                       irq_valid, fiq_valid, nirq_q, nfiq_q;
  logic [CH_W-1:0]            irq_ch, fiq_ch;
  logic [LVL_W-1:0]           irq_lvl;
  logic [LVL_W:0]             thr;
  logic                       unused_bits;

  assign unused_bits = ^{pwdata[31:5], paddr[1:0]};
  assign pready   = 1'b1;
  assign wr       = psel & penable & pwrite;
  assign rd       = psel & penable & ~pwrite;
  assign word_idx = paddr[11:2];
  assign ctrl_hit = int'(word_idx) < NSRC;
  assign ack_irq  = rd && paddr == OFS_IRQ_VEC && irq_valid;
  assign ack_fiq  = rd && paddr == OFS_FIQ_VEC && fiq_valid;
  assign pop      = wr && paddr == OFS_EOC;

  always_comb begin
    ack_v = '0;
    if (ack_irq) ack_v[irq_ch] = 1'b1;
    if (ack_fiq) ack_v[fiq_ch] = 1'b1;
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      lvl_q  <= '1;
      mode_q <= '0;
      en_q   <= '0;
    end else if (wr) begin
      if (ctrl_hit) begin
        lvl_q[word_idx[CH_W-1:0]]  <= pwdata[LVL_W-1:0];
        mode_q[word_idx[CH_W-1:0]] <= pwdata[4:3];
      end
      if (paddr == OFS_EN_SET) en_q <= en_q | pwdata[NSRC-1:0];
      if (paddr == OFS_EN_CLR) en_q <= en_q & ~pwdata[NSRC-1:0];
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irq_src_cond u_cond (
      .clk     (pclk),
      .rst_n   (presetn),
      .pin     (src_i[g]),
      .mode    (sense_mode_e'(mode_q[g])),
      .ack_clr (ack_v[g]),
      .raw     (raw_v[g]),
      .req     (req_v[g])
    );
  end

  irq_arbiter #(.NSRC(NSRC)) u_arb (
    .req       (req_v & en_q),
    .lvl       (lvl_q),
    .thr       (thr),
    .irq_valid (irq_valid),
    .irq_ch    (irq_ch),
    .irq_lvl   (irq_lvl),
    .fiq_valid (fiq_valid),
    .fiq_ch    (fiq_ch)
  );

  isr_stack u_stack (
    .clk      (pclk),
    .rst_n    (presetn),
    .push     (ack_irq | ack_fiq),
    .push_lvl (ack_fiq ? '0 : irq_lvl),
    .pop      (pop),
    .thr      (thr)
  );

  always_comb begin
    prdata = '0;
    if (ctrl_hit) begin
      prdata[LVL_W-1:0] = lvl_q[word_idx[CH_W-1:0]];
      prdata[4:3]       = mode_q[word_idx[CH_W-1:0]];
    end else begin
      unique case (paddr)
        OFS_EN_SET:  prdata = 32'(en_q);
        OFS_RAW:     prdata = 32'(raw_v);
        OFS_PEND:    prdata = 32'(req_v);
        OFS_IRQ_VEC: prdata = irq_valid ? {1'b1, 31'(irq_ch)} : '0;
        OFS_FIQ_VEC: prdata = fiq_valid ? {1'b1, 31'(fiq_ch)} : '0;
        default:     prdata = '0;
      endcase
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      nirq_q <= 1'b1;
      nfiq_q <= 1'b1;
    end else begin
      nirq_q <= ~irq_valid;
      nfiq_q <= ~fiq_valid;
    end
  end
  assign nirq_o = nirq_q;
  assign nfiq_o = nfiq_q;

  assert_irq_winner_enabled_R3: assert property (@(posedge pclk) disable iff (!presetn)
    irq_valid |-> (en_q[irq_ch] && req_v[irq_ch]));
  assert_irq_above_service_R9: assert property (@(posedge pclk) disable iff (!presetn)
    irq_valid |-> ({1'b0, irq_lvl} < thr && irq_lvl == lvl_q[irq_ch]));
  assert_fiq_is_level0_R7: assert property (@(posedge pclk) disable iff (!presetn)
    fiq_valid |-> (lvl_q[fiq_ch] == '0 && en_q[fiq_ch]));
  assert_fiq_masked_in_level0_R11: assert property (@(posedge pclk) disable iff (!presetn)
    (thr == '0) |=> nfiq_o);
  assert_single_ack_R8: assert property (@(posedge pclk) disable iff (!presetn)
    $onehot0(ack_v));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        pclk = 1'b0, presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        pready, nirq_o, nfiq_o;
  logic [N-1:0] src_i = '0;

  prio_irq_ctrl #(.NSRC(N)) i_prio_irq_ctrl (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .src_i(src_i), .nirq_o(nirq_o), .nfiq_o(nfiq_o));

  always #(CLK_PERIOD/2) pclk = ~pclk;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  int lvl[N], mode[N], stk[8], depth = 0;
  bit en[N], pin[N], flag[N];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge pclk);
  endtask

  task automatic apb_wr(logic [11:0] a, logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(posedge pclk); #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1; #1 d = prdata;
    @(posedge pclk); #1 psel = 0; penable = 0;
  endtask

  function automatic bit pend(int i);
    case (mode[i])
      0: return pin[i];
      1: return !pin[i];
      default: return flag[i];
    endcase
  endfunction

  function automatic int thr();
    return depth == 0 ? 8 : stk[depth-1];
  endfunction

  function automatic int win_irq();
    int best = 8, ch = -1;
    for (int i = 0; i < N; i++)
      if (en[i] && pend(i) && lvl[i] != 0 && lvl[i] < thr() && lvl[i] < best) begin
        best = lvl[i]; ch = i;
      end
    return ch;
  endfunction

  function automatic int win_fiq();
    if (thr() == 0) return -1;
    for (int i = 0; i < N; i++)
      if (en[i] && pend(i) && lvl[i] == 0) return i;
    return -1;
  endfunction

  function automatic logic [31:0] pend_vec();
    logic [31:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = pend(i);
    return v;
  endfunction

  task automatic cfg(int i, int l, int m);
    lvl[i] = l; mode[i] = m;
    if (m < 2) flag[i] = 0;
    apb_wr(12'(4*i), 32'((m << 3) | l));
    cycles(2);
  endtask

  task automatic set_en(int i, bit v);
    en[i] = v;
    apb_wr(v ? 12'h080 : 12'h084, 32'h1 << i);
  endtask

  task automatic set_pin(int i, bit v);
    if (mode[i] == 3 && !pin[i] && v) flag[i] = 1;
    if (mode[i] == 2 && pin[i] && !v) flag[i] = 1;
    pin[i] = v;
    @(negedge pclk); src_i[i] = v;
    cycles(6);
  endtask

  task automatic check_out(string tag);
    logic [31:0] d;
    chk(nirq_o == (win_irq() < 0), {tag, " nirq_o"}, 32'(nirq_o), 32'(win_irq() < 0));
    chk(nfiq_o == (win_fiq() < 0), {tag, " nfiq_o"}, 32'(nfiq_o), 32'(win_fiq() < 0));
    apb_rd(12'h08C, d);
    chk(d == pend_vec(), {tag, " pending"}, d, pend_vec());
  endtask

  task automatic ack(bit fast, string tag);
    logic [31:0] d, exp;
    int w;
    w = fast ? win_fiq() : win_irq();
    exp = (w < 0) ? 32'h0 : (32'h8000_0000 | 32'(w));
    apb_rd(fast ? 12'h094 : 12'h090, d);
    chk(d == exp, {tag, " vector"}, d, exp);
    if (w >= 0) begin
      stk[depth] = fast ? 0 : lvl[w];
      depth++;
      if (mode[w] >= 2) flag[w] = 0;
    end
    cycles(3);
  endtask

  task automatic eoc();
    apb_wr(12'h098, 32'h0);
    if (depth > 0) depth--;
    cycles(3);
  endtask

  initial begin
    repeat (200000) @(posedge pclk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int s;
    for (int i = 0; i < N; i++) begin lvl[i] = 7; mode[i] = 0; en[i] = 0; pin[i] = 0; flag[i] = 0; end
    s = $urandom(32'd2024);
    cycles(3);
    #1 presetn = 1;
    cycles(2);

    // R1 reset state
    apb_rd(12'h014, d); chk(d == 32'h7, "R1 ctrl reset", d, 32'h7);
    apb_rd(12'h080, d); chk(d == 32'h0, "R1 enables reset", d, 32'h0);
    check_out("R1");
    ack(0, "R8 empty irq read");
    ack(1, "R8 empty fiq read");
    eoc(); // R10 pop on empty stack

    // R2 readback, R4 low-level polarity, R3 enable/disable
    cfg(5, 4, 1);
    apb_rd(12'h014, d); chk(d == 32'h0C, "R2 ctrl readback", d, 32'h0C);
    set_en(5, 1); cycles(3);
    apb_rd(12'h080, d); chk(d == 32'h20, "R3 enable readback", d, 32'h20);
    check_out("R4 low-level");
    set_en(5, 0); cycles(3);
    check_out("R3 disabled");
    set_pin(7, 1);
    apb_rd(12'h088, d); chk(d == 32'h80, "R4 raw", d, 32'h80);
    set_pin(7, 0);

    // R5 edge latch held after pulse, R8 auto-clear on ack
    cfg(9, 2, 3); set_en(9, 1);
    set_pin(9, 1); set_pin(9, 0);
    check_out("R5 edge held");
    ack(0, "R8 edge ack");
    check_out("R8 flag cleared");
    eoc(); check_out("R10 pop");

    // R6 tie at same level, R9 nesting
    cfg(12, 3, 0); cfg(10, 3, 0); set_en(12, 1); set_en(10, 1);
    set_pin(12, 1); set_pin(10, 1);
    ack(0, "R6 tie lower channel");
    check_out("R9 same level masked");
    cfg(20, 2, 0); set_en(20, 1); set_pin(20, 1);
    check_out("R9 higher level nests");
    ack(0, "R9 nested ack");
    // R7 fast line during service, R11 masked once level 0 in service
    cfg(25, 0, 0); set_en(25, 1); set_pin(25, 1);
    check_out("R7 fiq preempts");
    ack(1, "R7 fiq vector");
    check_out("R11 fiq masked");
    eoc(); check_out("R10 pop 1");
    eoc(); check_out("R10 pop 2");
    eoc(); check_out("R10 pop 3");
    eoc(); check_out("R10 empty pop");

    // constrained random phase: R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < N; i++) begin
      cfg(i, int'($urandom % 8), int'($urandom % 4));
      set_en(i, 1'($urandom % 3 != 0));
    end
    check_out("R2 random config");
    for (int it = 0; it < 300; it++) begin
      int op = int'($urandom % 10);
      if (op < 6) begin
        int c = int'($urandom % N);
        set_pin(c, !pin[c]);
      end else if (op < 8) ack(0, "R6 random irq ack");
      else if (op == 8) ack(1, "R7 random fiq ack");
      else eoc();
      check_out("R9 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule